// File: doc/BRIEF.md
# Memory-Mapped SPI Word Shift Controller

This block is an SPI master (mode 0) that software drives through a small 32-bit register bus. Each command shifts a single word of 1 to 32 bits. Software first loads the transmit word, then writes one control word that picks a chip-select line, gives the bit count and may ask for chip select to be released once the word ends. The control word's top bit reads back as a busy flag until the last bit has gone out. After that the received bits can be read from their own register.

Chip select can stay low across several commands. A long frame can therefore be built from a sequence of words, and a terminate bit or a control write of zero ends it. Words are right-aligned in both data registers. The top bit of the programmed width goes out first, and the last bit sampled lands in bit 0. A function-select register gates the shift engine: commands start only when bit 0 of that register is 1. The clock register holds a divider for SCLK, a chip-select hold count and two stored option flags.

Top module: `spi_word_master`

## Requirements
- R1: After reset all chip selects are high, SCLK and MOSI are low, and every register reads 0.
- R2: Registers sit at 0x00 (function select, bit 0), 0x04 (clock: divider [4:0], flags [7:6], hold [13:8], other bits read 0), 0x10 (transmit word, all 32 bits) and 0x14 (control). Control reads back the accepted chip-select field [30:28], the terminate bit [26] and the count field [5:0]. All of these read back as written. Register reads return data one clock after the address is presented.
- R3: While function-select bit 0 is 0, a control write with bit 31 set is stored but starts nothing: busy reads 0, no SCLK pulse appears and every chip select stays high.
- R4: A control write with bit 31 set starts a transfer of the already-loaded transmit word. Control bit 31 reads 1 until the transfer (including any chip-select hold) ends, then reads 0.
- R5: Control bit 28+n (n = 0..2) selects chip select n, which is driven low at the start of the transfer while the others stay high. If several of these bits are set, the lowest one wins.
- R6: The count field [5:0] gives the number of bits N (1..32). A value of 0, or any value above 32, shifts 32 bits.
- R7: Bit N-1 of the transmit word goes out on MOSI first and bit 0 goes out last. Transmit bits at N and above are never sent.
- R8: The receive register at 0x18 holds the N sampled bits right-aligned, with the last sampled bit in bit 0 and zeros above bit N-1.
- R9: SCLK idles low, and each SCLK half-period lasts divider+1 system clocks. MOSI changes only on falling SCLK edges (or when a transfer starts), and MISO is sampled on rising edges.
- R10: With terminate (bit 26) set, chip select is released hold+1 system clocks after the final falling SCLK edge. With terminate clear, chip select stays low after the transfer.
- R11: A control write of 0 while idle drives every chip select high.
- R12: A control write while busy is ignored: the control fields, the selected line and the transfer in progress are unchanged. The receive register changes only when a transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous clock |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
A bench slave model answers each word with its own pattern, and a scoreboard compares both the captured MOSI word and the read-back receive word against masked expectations. The widths covered are 1, 8, 13 and 32 bits, plus count fields of 0 and 40. Transmit words carry set bits above N, so the order of bits on the wire and the masking of unused bits can be told apart. Patterns with asymmetric halves expose any swap of shift direction. Separate sequences cover:
- a command in memory mode;
- a command that arrives while busy;
- two words chained under one chip select and then released by a zero write;
- a slow divider with a hold count, where the SCLK high width and the chip-select release delay are counted in system clocks.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] A_FSEL = 8'h00;
  localparam logic [7:0] A_CLK  = 8'h04;
  localparam logic [7:0] A_TXD  = 8'h10;
  localparam logic [7:0] A_CTL  = 8'h14;
  localparam logic [7:0] A_RXD  = 8'h18;

  localparam int unsigned CTL_GO_BIT   = 31;
  localparam int unsigned CTL_CS_LSB   = 28;
  localparam int unsigned CTL_TERM_BIT = 26;
  localparam int unsigned CLK_FLAG_LSB = 6;
  localparam int unsigned CLK_HOLD_LSB = 8;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_HOLD  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spiw_tick.sv
module spiw_tick #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spiw_regs.sv
module spiw_regs
  import spiw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 5,
  parameter int HOLD_W = 6,
  parameter int CNT_W  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                busy,
  input  logic [WORD_W-1:0]   rx_data,
  output logic [DIV_W-1:0]    div,
  output logic [HOLD_W-1:0]   hold,
  output logic [WORD_W-1:0]   tx_data,
  output logic [NUM_CS-1:0]   cs_pick,
  output logic                term,
  output logic [CNT_W-1:0]    count,
  output logic                start,
  output logic                release_all
);
  logic              fsel_q;
  logic [DIV_W-1:0]  div_q;
  logic [1:0]        flag_q;
  logic [HOLD_W-1:0] hold_q;
  logic [WORD_W-1:0] tx_q;
  logic [NUM_CS-1:0] ctl_cs_q;
  logic              ctl_term_q;
  logic [CNT_W-1:0]  ctl_cnt_q;
  logic              ctl_wr, ctl_accept;
  logic [WORD_W-1:0] clk_word, ctl_word;

  assign ctl_wr      = bus_wr && (bus_addr == ADDR_W'(A_CTL));
  assign ctl_accept  = ctl_wr && !busy;
  assign start       = ctl_accept && bus_wdata[CTL_GO_BIT] && fsel_q;
  assign release_all = ctl_accept && (bus_wdata == '0);
  assign term        = bus_wdata[CTL_TERM_BIT];
  assign count       = bus_wdata[CNT_W-1:0];
  assign div         = div_q;
  assign hold        = hold_q;
  assign tx_data     = tx_q;

  // lowest requested chip select wins
  always_comb begin
    cs_pick = '0;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (bus_wdata[CTL_CS_LSB + i]) cs_pick = NUM_CS'(1) << i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q     <= 1'b0;
      div_q      <= '0;
      flag_q     <= '0;
      hold_q     <= '0;
      tx_q       <= '0;
      ctl_cs_q   <= '0;
      ctl_term_q <= 1'b0;
      ctl_cnt_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_FSEL)) fsel_q <= bus_wdata[0];
      if (bus_addr == ADDR_W'(A_CLK)) begin
        div_q  <= bus_wdata[DIV_W-1:0];
        flag_q <= bus_wdata[CLK_FLAG_LSB +: 2];
        hold_q <= bus_wdata[CLK_HOLD_LSB +: HOLD_W];
      end
      if (bus_addr == ADDR_W'(A_TXD)) tx_q <= bus_wdata;
      if (ctl_accept) begin
        ctl_cs_q   <= cs_pick;
        ctl_term_q <= bus_wdata[CTL_TERM_BIT];
        ctl_cnt_q  <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    clk_word = '0;
    clk_word[DIV_W-1:0]            = div_q;
    clk_word[CLK_FLAG_LSB +: 2]    = flag_q;
    clk_word[CLK_HOLD_LSB +: HOLD_W] = hold_q;
    ctl_word = '0;
    ctl_word[CTL_GO_BIT]             = busy;
    ctl_word[CTL_CS_LSB +: NUM_CS]   = ctl_cs_q;
    ctl_word[CTL_TERM_BIT]           = ctl_term_q;
    ctl_word[CNT_W-1:0]              = ctl_cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        ADDR_W'(A_FSEL): bus_rdata <= {{(WORD_W-1){1'b0}}, fsel_q};
        ADDR_W'(A_CLK):  bus_rdata <= clk_word;
        ADDR_W'(A_TXD):  bus_rdata <= tx_q;
        ADDR_W'(A_CTL):  bus_rdata <= ctl_word;
        ADDR_W'(A_RXD):  bus_rdata <= rx_data;
        default:         bus_rdata <= '0;
      endcase
    end
  end

  // a command arriving while busy must not alter the stored control fields
  assert_ctl_locked_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && ctl_wr) |=> ($stable(ctl_cs_q) && $stable(ctl_cnt_q) && $stable(ctl_term_q)));
endmodule

// File: rtl/spiw_engine.sv
module spiw_engine
  import spiw_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int HOLD_W = 6,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              release_all,
  input  logic [NUM_CS-1:0] cs_pick,
  input  logic              term,
  input  logic [CNT_W-1:0]  count,
  input  logic [WORD_W-1:0] tx_data,
  input  logic [HOLD_W-1:0] hold,
  input  logic              tick,
  input  logic              spi_miso,
  output logic              shifting,
  output logic              busy,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic [WORD_W-1:0] rx_data
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  eng_state_t        state;
  logic              sclk_q;
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_q, tx_aligned;
  logic [CNT_W-1:0]  left, nbits;
  logic              term_q;
  logic [HOLD_W-1:0] hold_q, hcnt;
  logic [NUM_CS-1:0] cs_n_q;

  always_comb begin
    nbits = ((count == '0) || (count > FULL)) ? FULL : count;
    tx_aligned = tx_data << (FULL - nbits);
  end

  assign shifting = (state == ENG_SHIFT);
  assign busy     = (state != ENG_IDLE);
  assign spi_sclk = sclk_q;
  assign spi_mosi = tx_sh[WORD_W-1];
  assign spi_cs_n = cs_n_q;
  assign rx_data  = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ENG_IDLE;
      sclk_q <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
      left   <= '0;
      term_q <= 1'b0;
      hold_q <= '0;
      hcnt   <= '0;
      cs_n_q <= '1;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (start) begin
            state  <= ENG_SHIFT;
            tx_sh  <= tx_aligned;
            rx_sh  <= '0;
            left   <= nbits;
            term_q <= term;
            hold_q <= hold;
            cs_n_q <= ~cs_pick;
            sclk_q <= 1'b0;
          end else if (release_all) begin
            cs_n_q <= '1;
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_sh  <= {rx_sh[WORD_W-2:0], spi_miso};
            end else begin
              sclk_q <= 1'b0;
              if (left == CNT_W'(1)) begin
                rx_q  <= rx_sh;
                hcnt  <= '0;
                state <= term_q ? ENG_HOLD : ENG_IDLE;
              end else begin
                left  <= left - CNT_W'(1);
                tx_sh <= tx_sh << 1;
              end
            end
          end
        end
        ENG_HOLD: begin
          if (hcnt == hold_q) begin
            cs_n_q <= '1;
            state  <= ENG_IDLE;
          end else begin
            hcnt <= hcnt + HOLD_W'(1);
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~spi_cs_n));

  assert_sclk_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sclk_q));

  assert_mosi_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(sclk_q)) |-> $stable(spi_mosi));

  assert_busy_from_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_rx_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (state != ENG_SHIFT) |=> $stable(rx_q));
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spiw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 5,
  parameter int HOLD_W = 6,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic [DIV_W-1:0]  div;
  logic [HOLD_W-1:0] hold;
  logic [WORD_W-1:0] tx_data, rx_data;
  logic [NUM_CS-1:0] cs_pick;
  logic [CNT_W-1:0]  count;
  logic              term, start, release_all, busy, shifting, tick;

  spiw_regs #(
    .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .DIV_W(DIV_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .rx_data(rx_data),
    .div(div), .hold(hold), .tx_data(tx_data), .cs_pick(cs_pick), .term(term),
    .count(count), .start(start), .release_all(release_all)
  );

  spiw_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(shifting), .div(div), .tick(tick)
  );

  spiw_engine #(.NUM_CS(NUM_CS), .HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst(rst), .start(start), .release_all(release_all),
    .cs_pick(cs_pick), .term(term), .count(count), .tx_data(tx_data),
    .hold(hold), .tick(tick), .spi_miso(spi_miso), .shifting(shifting),
    .busy(busy), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .rx_data(rx_data)
  );
endmodule

// File: tb/tb_spi_word_master.sv
`timescale 1ns/1ps
module tb_spi_word_master;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  spi_cs_n;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_word_master dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // slave model: counts falling edges, presents pattern bits from the top
  int fall_cnt = 0;
  int base_fall = 0;
  int slave_n = 1;
  int miso_idx;
  logic [31:0] slave_pat = '0;
  logic [31:0] mosi_cap = '0;

  always @(negedge spi_sclk) fall_cnt <= fall_cnt + 1;
  always @(posedge spi_sclk) mosi_cap <= {mosi_cap[30:0], spi_mosi};
  assign miso_idx = slave_n - 1 - (fall_cnt - base_fall);
  assign spi_miso = (miso_idx >= 0 && miso_idx < 32) ? slave_pat[miso_idx] : 1'b0;

  typedef struct {
    string       req;
    logic [31:0] rx;
    logic [31:0] tx;
  } item_t;
  item_t exp_q[$];
  item_t act_q[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e, a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      chk(e.req, "rx word (R8)", a.rx, e.rx);
      chk(e.req, "mosi word (R7)", a.tx, e.tx);
    end
  end

  function automatic logic [31:0] mask_n(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] r;
    int guard = 0;
    bus_read(8'h14, r);
    while (r[31] && guard < 20000) begin
      bus_read(8'h14, r);
      guard++;
    end
    if (guard >= 20000) chk(req, "busy never cleared", r[31], 32'd0);
  endtask

  task automatic arm_slave(int n, logic [31:0] pat);
    slave_pat = pat; slave_n = n; base_fall = fall_cnt;
  endtask

  task automatic xfer(string req, int cs, int cnt_field, int n,
                      logic [31:0] tx, logic [31:0] pat, bit term);
    logic [31:0] r, rx;
    item_t e, a;
    e.req = req; e.rx = pat & mask_n(n); e.tx = tx & mask_n(n);
    exp_q.push_back(e);
    arm_slave(n, pat);
    bus_write(8'h10, tx);
    bus_write(8'h14, 32'h8000_0000 | (32'h1 << (28 + cs)) | (32'(term) << 26) | 32'(cnt_field));
    chk("R5", "selected line low", 32'(spi_cs_n), 32'(~(3'b001 << cs) & 3'b111));
    bus_read(8'h14, r);
    chk("R4", "busy bit while shifting", 32'(r[31]), 32'd1);
    wait_idle(req);
    bus_read(8'h18, rx);
    a.req = req; a.rx = rx; a.tx = mosi_cap & mask_n(n);
    act_q.push_back(a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL R4 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int hi;
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", "cs_n after reset", 32'(spi_cs_n), 32'h7);
    chk("R1", "sclk after reset", 32'(spi_sclk), 32'h0);
    chk("R1", "mosi after reset", 32'(spi_mosi), 32'h0);
    bus_read(8'h00, r); chk("R1", "fsel reset", r, 32'h0);
    bus_read(8'h04, r); chk("R1", "clock reset", r, 32'h0);
    bus_read(8'h14, r); chk("R1", "ctrl reset", r, 32'h0);
    bus_read(8'h18, r); chk("R1", "rx reset", r, 32'h0);

    // R3 memory mode: start stored but not run
    bus_write(8'h10, 32'h0000_00A5);
    bus_write(8'h14, 32'h9000_0008);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (spi_sclk) hi++;
    end
    chk("R3", "sclk pulses in memory mode", 32'(hi), 32'd0);
    chk("R3", "cs_n in memory mode", 32'(spi_cs_n), 32'h7);
    bus_read(8'h14, r); chk("R3", "ctrl readback no busy", r, 32'h1000_0008);

    // R2 register readback
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, r); chk("R2", "clock readback mask", r, 32'h0000_3FDF);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, r); chk("R2", "fsel readback", r, 32'h1);
    bus_read(8'h10, r); chk("R2", "tx readback", r, 32'h0000_00A5);
    bus_write(8'h04, 32'h0000_0001);

    // R7 R8 R6 transfers under several widths
    xfer("R7", 0, 8, 8, 32'hFFFF_FF3C, 32'h0000_005A, 1'b1);
    chk("R10", "cs released after terminate", 32'(spi_cs_n), 32'h7);
    xfer("R8", 1, 32, 32, 32'hDEAD_BEEF, 32'h1357_2468, 1'b1);
    xfer("R7", 2, 1, 1, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1);
    xfer("R8", 0, 13, 13, 32'hFFFF_1ABC, 32'hFFFF_0F0F, 1'b1);
    xfer("R6", 1, 0, 32, 32'h8000_0001, 32'hC000_0003, 1'b1);
    xfer("R6", 2, 40, 32, 32'h0F0F_00FF, 32'hF0F0_FF00, 1'b1);

    // R10 chained words without terminate, R11 release by zero write
    xfer("R10", 0, 8, 8, 32'h0000_00C3, 32'h0000_0081, 1'b0);
    chk("R10", "cs held after non-terminate", 32'(spi_cs_n), 32'h6);
    xfer("R10", 0, 8, 8, 32'h0000_0077, 32'h0000_0011, 1'b0);
    chk("R10", "cs still held after second word", 32'(spi_cs_n), 32'h6);
    bus_write(8'h14, 32'h0);
    chk("R11", "zero write releases all", 32'(spi_cs_n), 32'h7);

    // R12 control write while busy is ignored
    bus_write(8'h04, 32'h0000_0007);
    begin
      item_t e, a;
      logic [31:0] rx;
      e.req = "R12"; e.rx = 32'h0000_B44D; e.tx = 32'h0000_1234;
      exp_q.push_back(e);
      arm_slave(16, 32'h0000_B44D);
      bus_write(8'h10, 32'h0000_1234);
      bus_write(8'h14, 32'h9000_0010);
      bus_write(8'h14, 32'hC400_0008);
      chk("R12", "cs unchanged by busy write", 32'(spi_cs_n), 32'h6);
      bus_read(8'h14, r); chk("R12", "ctrl fields unchanged", r, 32'h9000_0010);
      wait_idle("R12");
      bus_read(8'h18, rx);
      a.req = "R12"; a.rx = rx; a.tx = mosi_cap & mask_n(16);
      act_q.push_back(a);
      bus_write(8'h14, 32'h2000_0000);
      bus_read(8'h18, r); chk("R12", "rx held without transfer", r, 32'h0000_B44D);
      chk("R12", "cs unchanged by non-go write", 32'(spi_cs_n), 32'h6);
      bus_write(8'h14, 32'h0);
    end

    // R9 half period and R10 hold count, div=2 hold=5
    bus_write(8'h04, 32'h0000_0502);
    arm_slave(4, 32'h5);
    bus_write(8'h10, 32'h0000_000A);
    bus_write(8'h14, 32'h8400_0000 | 32'h2000_0000 | 32'd4);
    begin
      int falls = 0, run_hi = 0, first_hi = -1, k = -1;
      logic prev = 1'b0;
      for (int i = 0; i < 500; i++) begin
        @(negedge clk);
        if (k >= 0) begin
          k++;
          if (spi_cs_n[1]) break;
        end
        if (spi_sclk) run_hi++;
        if (prev && !spi_sclk) begin
          if (first_hi < 0) first_hi = run_hi;
          run_hi = 0;
          falls++;
          if (falls == 4) k = 0;
        end
        prev = spi_sclk;
      end
      chk("R9", "sclk high width", 32'(first_hi), 32'd3);
      chk("R10", "hold clocks before release", 32'(k), 32'd6);
    end
    chk("R9", "sclk idle low", 32'(spi_sclk), 32'h0);
    chk("R7", "mosi word in timed run", mosi_cap & 32'hF, 32'hA);
    bus_read(8'h18, r); chk("R8", "rx word in timed run", r, 32'h5);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule